// File: doc/BRIEF.md
# Paged Control Register File

This block holds a set of 8-bit control registers reached through a 7-bit in-page address. A page pointer selects which of 256 possible pages the address applies to. The pointer sits at address 0 and stays reachable whatever page is selected, so software can always switch to another page, including away from a reserved one. Only seven pages hold storage: 0, 1 and 3 for configuration, 8 and 9 for coefficient buffer A, and 12 and 13 for coefficient buffer B. Every other page is reserved.

A host-side front end turns serial bus transactions into single-cycle accesses on the register port. The port has a write strobe, a read strobe, an address and write data, and read data comes back registered. The configuration pages drive flat output buses that downstream logic decodes. Page 0 also holds a self-clearing software-reset bit. Setting it returns the whole register file to its reset state and emits a one-cycle pulse that other logic can use.

Top module: `paged_ctrl_regs`

## Requirements
- R1: After the reset input is released, the page pointer is 0, `rdata_o` is 0x00 and `swrst_o` is low. Every storage register holds its reset value: 0x01 on page 3 and 0x00 on all other pages.
- R2: On every page, including reserved pages, address 0 is the page pointer. A write loads all 8 bits (0 to 255), and a read returns the current pointer.
- R3: Page 0 addresses 4..11, page 1 addresses 1..16 and page 3 addresses 1..16 are read/write. They read back the last value written. Byte i of `cfg_p0_o`, `cfg_p1_o` and `cfg_p3_o` (bits 8i+7..8i) equals the register at the page's first address plus i.
- R4: Pages 8 and 9 (buffer A) and pages 12 and 13 (buffer B) hold read/write storage at addresses 1..32. The same address on different pages names distinct storage.
- R5: Writing page 0 address 1 with bit 0 = 1 raises `swrst_o` for exactly the one cycle after the write. At the end of that cycle every storage register and the page pointer return to their R1 values. Writing bit 0 = 0 has no effect.
- R6: Page 0 address 1 always reads 0x00.
- R7: Page 0 address 2 is reserved: it reads 0x00 and writes to it are ignored. Page 0 address 3 is a read-only status register: it returns `status_i`, and writes to it are ignored.
- R8: On reserved pages, and at addresses of implemented pages not listed in R3 to R7, writes are ignored and reads return 0x00.
- R9: `rdata_o` takes the addressed value at the clock edge that samples `re_i`, and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe, one access per cycle |
| re_i | input | 1 | Read strobe |
| addr_i | input | 7 | In-page register address |
| wdata_i | input | 8 | Write data |
| status_i | input | 8 | Live status value shown at page 0 address 3 |
| rdata_o | output | 8 | Registered read data |
| swrst_o | output | 1 | One-cycle software-reset pulse |
| cfg_p0_o | output | 8*P0_REGS | Page 0 configuration registers, flat |
| cfg_p1_o | output | 8*P1_REGS | Page 1 configuration registers, flat |
| cfg_p3_o | output | 8*P3_REGS | Page 3 configuration registers, flat |

## Verification
The hardest situation to reach is a software reset that arrives after long random traffic has left non-default values spread across several pages, with the pointer parked somewhere other than page 0. Only then does a clear that misses a page, or leaves the pointer behind, show up. The random stream reaches this by letting writes land on page 0 address 1 with random data, so about half of them set bit 0. The bench model then resets every page and the pointer, and later reads and flat-bus comparisons expose any stale byte. Directed steps cover the first and last address of each bank, a round trip through page 255, and a check that `rdata_o` holds while the register it last returned is rewritten.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
   localparam int unsigned DW        = 8;
   localparam int unsigned AW        = 7;
   localparam int unsigned PW        = 8;
   localparam int unsigned N_PG      = 7;
   localparam int unsigned PTR_ADDR  = 0;
   localparam int unsigned SRST_ADDR = 1;
   localparam int unsigned RSV_ADDR  = 2;
   localparam int unsigned STAT_ADDR = 3;

   typedef logic [DW-1:0] reg_t;
   typedef logic [AW-1:0] addr_t;
   typedef logic [PW-1:0] page_t;

   // page number owned by bank slot k
   function automatic page_t pg_num(input int unsigned k);
      case (k)
         0: pg_num = 8'd0;
         1: pg_num = 8'd1;
         2: pg_num = 8'd3;
         3: pg_num = 8'd8;
         4: pg_num = 8'd9;
         5: pg_num = 8'd12;
         default: pg_num = 8'd13;
      endcase
   endfunction
endpackage

// File: rtl/pgreg_page_ptr.sv
module pgreg_page_ptr
   import pgreg_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  we_i,
   input  addr_t addr_i,
   input  reg_t  wdata_i,
   output page_t page_o,
   output logic  swrst_o
);
   page_t page_q;
   logic  srst_q;
   logic  srst_hit;

   assign srst_hit = we_i && (page_q == '0) && (addr_i == AW'(SRST_ADDR)) && wdata_i[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         page_q <= '0;
         srst_q <= 1'b0;
      end else begin
         srst_q <= srst_hit;
         if (srst_q)
            page_q <= '0;
         else if (we_i && (addr_i == AW'(PTR_ADDR)))
            page_q <= wdata_i;
      end
   end

   assign page_o  = page_q;
   assign swrst_o = srst_q;
endmodule

// File: rtl/pgreg_decode.sv
module pgreg_decode
   import pgreg_pkg::*;
(
   input  page_t           page_i,
   output logic [N_PG-1:0] sel_o
);
   for (genvar k = 0; k < N_PG; k++) begin : g_sel
      assign sel_o[k] = (page_i == pg_num(k));
   end
endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank
   import pgreg_pkg::*;
#(
   parameter int unsigned BASE    = 1,
   parameter int unsigned DEPTH   = 16,
   parameter logic [7:0]  RST_VAL = 8'h00,
   localparam int unsigned FW     = DEPTH * DW
)(
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          sel_i,
   input  logic          we_i,
   input  addr_t         addr_i,
   input  reg_t          wdata_i,
   output logic          hit_o,
   output logic [FW-1:0] flat_o
);
   localparam logic [AW:0] LO = (AW+1)'(BASE);
   localparam logic [AW:0] HI = (AW+1)'(BASE + DEPTH);

   if (BASE + DEPTH > (1 << AW)) begin : g_bad_range
      $error("pgreg_bank: BASE+DEPTH exceeds the page size");
   end
   if (DEPTH == 0) begin : g_bad_depth
      $error("pgreg_bank: DEPTH must be nonzero");
   end

   logic [AW:0] a_ext;
   assign a_ext = {1'b0, addr_i};
   assign hit_o = sel_i && (a_ext >= LO) && (a_ext < HI);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < DEPTH; i++) flat_o[i*DW +: DW] <= RST_VAL;
      end else if (clr_i) begin
         for (int i = 0; i < DEPTH; i++) flat_o[i*DW +: DW] <= RST_VAL;
      end else if (we_i && hit_o) begin
         for (int i = 0; i < DEPTH; i++)
            if (a_ext == (AW+1)'(BASE + i)) flat_o[i*DW +: DW] <= wdata_i;
      end
   end
endmodule

// File: rtl/pgreg_rdsel.sv
module pgreg_rdsel
   import pgreg_pkg::*;
#(
   parameter int unsigned BASE  = 1,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned FW   = DEPTH * DW
)(
   input  logic [FW-1:0] flat_i,
   input  logic          hit_i,
   input  addr_t         addr_i,
   output reg_t          byte_o
);
   always_comb begin
      byte_o = '0;
      for (int i = 0; i < DEPTH; i++)
         if (hit_i && ({1'b0, addr_i} == (AW+1)'(BASE + i))) byte_o = flat_i[i*DW +: DW];
   end
endmodule

// File: rtl/paged_ctrl_regs.sv
module paged_ctrl_regs
   import pgreg_pkg::*;
#(
   parameter int unsigned P0_BASE   = 4,
   parameter int unsigned P0_REGS   = 8,
   parameter int unsigned P1_REGS   = 16,
   parameter int unsigned P3_REGS   = 16,
   parameter logic [7:0]  P3_RST    = 8'h01,
   parameter int unsigned COEF_REGS = 32
)(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 we_i,
   input  logic                 re_i,
   input  logic [6:0]           addr_i,
   input  logic [7:0]           wdata_i,
   input  logic [7:0]           status_i,
   output logic [7:0]           rdata_o,
   output logic                 swrst_o,
   output logic [8*P0_REGS-1:0] cfg_p0_o,
   output logic [8*P1_REGS-1:0] cfg_p1_o,
   output logic [8*P3_REGS-1:0] cfg_p3_o
);
   if (P0_BASE <= STAT_ADDR) begin : g_bad_p0
      $error("paged_ctrl_regs: page 0 storage overlaps fixed addresses 0..3");
   end

   function automatic int unsigned bk_base(input int unsigned k);
      return (k == 0) ? P0_BASE : 1;
   endfunction
   function automatic int unsigned bk_depth(input int unsigned k);
      case (k)
         0: return P0_REGS;
         1: return P1_REGS;
         2: return P3_REGS;
         default: return COEF_REGS;
      endcase
   endfunction
   function automatic logic [7:0] bk_rst(input int unsigned k);
      return (k == 2) ? P3_RST : 8'h00;
   endfunction

   page_t           page_q;
   logic            clr;
   logic [N_PG-1:0] sel;
   logic [N_PG-1:0] hit_v;
   reg_t            byte_v [N_PG];
   reg_t            rd_nx;
   reg_t            rd_q;

   pgreg_page_ptr i_ptr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .page_o  (page_q),
      .swrst_o (clr)
   );

   pgreg_decode i_dec (
      .page_i (page_q),
      .sel_o  (sel)
   );

   for (genvar k = 0; k < N_PG; k++) begin : g_bank
      localparam int unsigned B = bk_base(k);
      localparam int unsigned D = bk_depth(k);
      logic [D*DW-1:0] flat;

      pgreg_bank #(.BASE(B), .DEPTH(D), .RST_VAL(bk_rst(k))) i_bank (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .clr_i   (clr),
         .sel_i   (sel[k]),
         .we_i    (we_i),
         .addr_i  (addr_i),
         .wdata_i (wdata_i),
         .hit_o   (hit_v[k]),
         .flat_o  (flat)
      );

      pgreg_rdsel #(.BASE(B), .DEPTH(D)) i_rdsel (
         .flat_i (flat),
         .hit_i  (hit_v[k]),
         .addr_i (addr_i),
         .byte_o (byte_v[k])
      );

      if (k == 0) begin : g_out0
         assign cfg_p0_o = flat;
      end else if (k == 1) begin : g_out1
         assign cfg_p1_o = flat;
      end else if (k == 2) begin : g_out3
         assign cfg_p3_o = flat;
      end
   end

   always_comb begin
      rd_nx = '0;
      if (addr_i == AW'(PTR_ADDR))
         rd_nx = page_q;
      else if (sel[0] && (addr_i == AW'(STAT_ADDR)))
         rd_nx = status_i;
      else
         for (int k = 0; k < N_PG; k++) rd_nx = rd_nx | byte_v[k];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (re_i) rd_q <= rd_nx;
   end

   assign rdata_o = rd_q;
   assign swrst_o = clr;
endmodule

// File: rtl/pgreg_checker.sv
module pgreg_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       we_i,
   input logic       re_i,
   input logic [6:0] addr_i,
   input logic [7:0] wdata_i,
   input logic [7:0] rdata_o,
   input logic       swrst_o,
   input logic [7:0] page_i
);
   logic impl;
   assign impl = (page_i == 8'd0) || (page_i == 8'd1) || (page_i == 8'd3) ||
                 (page_i == 8'd8) || (page_i == 8'd9) || (page_i == 8'd12) || (page_i == 8'd13);

   AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == 7'd0 && !swrst_o) |=> (page_i == $past(wdata_i))); // R2
   AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(we_i && addr_i == 7'd0) && !swrst_o) |=> $stable(page_i)); // R2
   AST_PTR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i && addr_i == 7'd0) |=> (rdata_o == $past(page_i))); // R2
   AST_SRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swrst_o |=> (page_i == 8'd0)); // R5
   AST_SRST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swrst_o |=> !swrst_o); // R5
   AST_SRST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swrst_o |-> $past(we_i && addr_i == 7'd1 && page_i == 8'd0 && wdata_i[0])); // R5
   AST_SRST_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i && addr_i == 7'd1 && page_i == 8'd0) |=> (rdata_o == 8'd0)); // R6
   AST_RSV_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i && addr_i != 7'd0 && !impl) |=> (rdata_o == 8'd0)); // R8
   AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !re_i |=> $stable(rdata_o)); // R9
endmodule

bind paged_ctrl_regs pgreg_checker i_pgreg_checker (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .we_i    (we_i),
   .re_i    (re_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .rdata_o (rdata_o),
   .swrst_o (swrst_o),
   .page_i  (page_q)
);

// File: tb/test_paged_ctrl_regs.sv
`timescale 1ns/1ps
module test_paged_ctrl_regs;
   localparam int P0B = 4;
   localparam int P0N = 8;
   localparam int P1N = 16;
   localparam int P3N = 16;
   localparam int CN  = 32;

   logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
   logic [6:0] addr = '0;
   logic [7:0] wd = '0, st = 8'h5A;
   logic [7:0] rd;
   logic       swrst;
   logic [8*P0N-1:0] cfg0;
   logic [8*P1N-1:0] cfg1;
   logic [8*P3N-1:0] cfg3;

   always #10 clk = ~clk;

   paged_ctrl_regs i_paged_ctrl_regs (
      .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
      .wdata_i(wd), .status_i(st), .rdata_o(rd), .swrst_o(swrst),
      .cfg_p0_o(cfg0), .cfg_p1_o(cfg1), .cfg_p3_o(cfg3)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] mdl [256][128];
   logic [7:0] mpage;

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20ns * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
   end

   function automatic bit is_rw(int p, int a);
      case (p)
         0: return (a >= P0B) && (a < P0B + P0N);
         1: return (a >= 1) && (a <= P1N);
         3: return (a >= 1) && (a <= P3N);
         8, 9, 12, 13: return (a >= 1) && (a <= CN);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] exp_rd(int a);
      if (a == 0) return mpage;
      if (mpage == 0 && a == 3) return st;
      if (is_rw(int'(mpage), a)) return mdl[mpage][a];
      return 8'h00;
   endfunction

   function automatic string tag_for(int a);
      if (a == 0) return "R2";
      if (mpage == 0 && a == 1) return "R6";
      if (mpage == 0 && (a == 2 || a == 3)) return "R7";
      if (is_rw(int'(mpage), a)) return (mpage >= 8) ? "R4" : "R3";
      return "R8";
   endfunction

   task automatic model_reset();
      for (int p = 0; p < 256; p++)
         for (int a = 0; a < 128; a++)
            mdl[p][a] = (p == 3 && is_rw(p, a)) ? 8'h01 : 8'h00;
      mpage = 8'h00;
   endtask

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_read(int a);
      logic [7:0] e;
      string t;
      e = exp_rd(a);
      t = tag_for(a);
      @(negedge clk); re = 1'b1; addr = 7'(a);
      @(negedge clk); re = 1'b0;
      chk(t, $sformatf("read p%0d a%0d", mpage, a), rd, e);
   endtask

   task automatic do_write(int a, logic [7:0] d);
      bit trig;
      trig = (a == 1) && (mpage == 0) && d[0];
      @(negedge clk); we = 1'b1; addr = 7'(a); wd = d;
      @(negedge clk); we = 1'b0;
      if (a == 0) mpage = d;
      else if (is_rw(int'(mpage), a)) mdl[mpage][a] = d;
      chk("R5", "pulse after write", {7'd0, swrst}, {7'd0, trig});
      if (trig) begin
         @(negedge clk);
         chk("R5", "pulse ends", {7'd0, swrst}, 8'h00);
         model_reset();
      end
   endtask

   task automatic chk_cfg();
      for (int i = 0; i < P0N; i++) chk("R3", "cfg_p0 byte", cfg0[i*8 +: 8], mdl[0][P0B+i]);
      for (int i = 0; i < P1N; i++) chk("R3", "cfg_p1 byte", cfg1[i*8 +: 8], mdl[1][1+i]);
      for (int i = 0; i < P3N; i++) chk("R3", "cfg_p3 byte", cfg3[i*8 +: 8], mdl[3][1+i]);
   endtask

   function automatic int pick_page();
      int r;
      r = int'($urandom_range(0, 9));
      case (r)
         0: return 0;
         1: return 1;
         2: return 3;
         3: return 8;
         4: return 9;
         5: return 12;
         6: return 13;
         7: return 0;
         default: return int'($urandom_range(0, 255));
      endcase
   endfunction

   initial begin
      logic [7:0] held;
      int unsigned seed;
      seed = $urandom(32'd20240611);
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "rdata after reset", rd, 8'h00);
      chk("R1", "swrst after reset", {7'd0, swrst}, 8'h00);
      chk_cfg();
      do_read(0);
      do_write(0, 8'd8); do_read(CN); do_read(CN + 1);
      // R2 pointer full range, exit from reserved page
      do_write(0, 8'd255); do_read(0);
      do_write(5, 8'hC3); do_read(5);              // R8 reserved page
      do_write(0, 8'd3);  do_read(1); do_read(P3N); // R1 page 3 value 0x01
      // R4 buffer isolation
      do_write(0, 8'd8);  do_write(5, 8'hAA);
      do_write(0, 8'd12); do_write(5, 8'h55); do_read(5);
      do_write(0, 8'd8);  do_read(5); do_write(CN, 8'h3C); do_read(CN);
      do_write(0, 8'd9);  do_read(5);
      // R7 / R6 on page 0
      do_write(0, 8'd0);
      do_write(2, 8'hFF); do_read(2);
      do_write(3, 8'h11); do_read(3);
      do_write(1, 8'hFE); do_read(1);
      do_write(P0B, 8'h81); do_write(P0B + P0N - 1, 8'h7E);
      do_read(P0B); do_read(P0B + P0N); do_read(P0B - 1);
      chk_cfg();
      // R9 hold while the returned register is rewritten
      do_read(P0B);
      held = rd;
      do_write(P0B, 8'h24);
      repeat (2) @(negedge clk);
      chk("R9", "rdata held", rd, held);
      // R5 directed software reset from a dirty state
      do_write(0, 8'd1); do_write(7, 8'h99);
      do_write(0, 8'd0); do_write(1, 8'h01);
      do_read(0); chk_cfg();
      do_write(0, 8'd8); do_read(5);
      do_write(0, 8'd0);
      // random traffic
      for (int n = 0; n < 1500; n++) begin
         int r, a;
         r = int'($urandom_range(0, 99));
         a = ($urandom_range(0, 9) < 8) ? int'($urandom_range(1, 40)) : int'($urandom_range(0, 127));
         if (r < 10) do_write(0, 8'(pick_page()));
         else if (r < 50) do_write(a, 8'($urandom()));
         else if (r < 95) do_read(a);
         else begin
            st = 8'($urandom());
            chk_cfg();
         end
      end
      do_write(0, 8'd0); do_write(1, 8'h01); chk_cfg(); do_read(0);
      summary();
   end
endmodule